// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit performs one single-position shift, rotate or inversion on an 8-, 16- or 32-bit operand and produces the new value together with four condition flags: negative, zero, overflow and carry. A caller presents an operand, a width select, a 4-bit operation code and the present carry flag, and raises `in_valid`. One clock later the result and flags appear on registered outputs, with `out_valid` high for exactly that cycle.

Each width has its own datapath lane. A lane works only on the low bits of the operand for its width. The width select picks one lane. The result is zero-extended to the full bus, so bits above the chosen width always read as zero. Negative and zero are taken at the chosen width. Overflow is always cleared. Carry takes the bit shifted out, or the old carry where the operation moves no bit out.

The unit has no multi-step state. The only sequencing is the output register: after a transfer, `out_valid` is high for one cycle, and it then stays low until the next request.

Top module: `shrot_unit`

## Requirements
- R1: The result and flags appear on the outputs one clock after `in_valid` is sampled high, and `out_valid` is high exactly in that cycle. Reset clears every output to zero.
- R2: The width select `size` takes 0 for 8 bits (bits 7:0), 1 for 16 bits and 2 or 3 for 32 bits. Operand bits above the width are ignored, and result bits above the width are zero.
- R3: Op 0 (logical left) and op 2 (arithmetic left) move every bit up by one place, put 0 in bit 0, and send the old top bit to C.
- R4: Op 1 (logical right) moves every bit down by one place, puts 0 in the top bit, and sends the old bit 0 to C.
- R5: Op 3 (arithmetic right) moves every bit down by one place, keeps the old top bit in the top position, and sends the old bit 0 to C.
- R6: Op 4 (rotate left) moves the old top bit into bit 0 and into C.
- R7: Op 5 (rotate right) moves the old bit 0 into the top bit and into C.
- R8: Op 6 (left through carry) puts the old C into bit 0 and the old top bit into C. Op 7 (right through carry) puts the old C into the top bit and the old bit 0 into C.
- R9: Op 8 inverts every bit within the width and leaves C equal to `carry_in`.
- R10: N equals the top bit of the result at the chosen width. Z is 1 exactly when the result at that width is zero.
- R11: V is 0 after every operation.
- R12: Op codes 9 to 15 return the operand unchanged within the width, with C equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| size | input | 2 | Width select |
| operand | input | 32 | Source value |
| carry_in | input | 1 | Present carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Shifted value, zero above the width |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always 0) |
| flag_c | output | 1 | Carry flag |

## Verification
Every result and every flag is due exactly one rising edge after the request is sampled. No output depends on more than one request. The bench drives each request on a falling edge and compares all outputs on the next falling edge, so exactly one rising edge lies between stimulus and sample. After each check it lowers `in_valid`, which lets it also confirm that `out_valid` falls one cycle later.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    typedef enum logic [3:0] {
        OP_SHL_LOG = 4'd0,
        OP_SHR_LOG = 4'd1,
        OP_SHL_ARI = 4'd2,
        OP_SHR_ARI = 4'd3,
        OP_ROT_L   = 4'd4,
        OP_ROT_R   = 4'd5,
        OP_ROTC_L  = 4'd6,
        OP_ROTC_R  = 4'd7,
        OP_INVERT  = 4'd8
    } shrot_op_e;

    localparam int NUM_LANES = 3;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] opnd,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int TOP = W - 1;

    always_comb begin
        res  = opnd;
        cout = cin;
        unique case (op)
            OP_SHL_LOG, OP_SHL_ARI: begin
                res  = {opnd[TOP-1:0], 1'b0};
                cout = opnd[TOP];
            end
            OP_SHR_LOG: begin
                res  = {1'b0, opnd[TOP:1]};
                cout = opnd[0];
            end
            OP_SHR_ARI: begin
                res  = {opnd[TOP], opnd[TOP:1]};
                cout = opnd[0];
            end
            OP_ROT_L: begin
                res  = {opnd[TOP-1:0], opnd[TOP]};
                cout = opnd[TOP];
            end
            OP_ROT_R: begin
                res  = {opnd[0], opnd[TOP:1]};
                cout = opnd[0];
            end
            OP_ROTC_L: begin
                res  = {opnd[TOP-1:0], cin};
                cout = opnd[TOP];
            end
            OP_ROTC_R: begin
                res  = {cin, opnd[TOP:1]};
                cout = opnd[0];
            end
            OP_INVERT: begin
                res  = ~opnd;
                cout = cin;
            end
            default: begin
                res  = opnd;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [1:0]        size,
    output logic              neg,
    output logic              zero
);
    localparam int W_BYTE = DATA_W / 4;
    localparam int W_HALF = DATA_W / 2;

    always_comb begin
        unique case (size)
            2'd0:    neg = res[W_BYTE-1];
            2'd1:    neg = res[W_HALF-1];
            default: neg = res[DATA_W-1];
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_c   [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
        logic [LW-1:0] r;
        logic          c;
        shrot_lane #(.W(LW)) u_lane (
            .op   (op),
            .opnd (operand[LW-1:0]),
            .cin  (carry_in),
            .res  (r),
            .cout (c)
        );
        assign lane_res[g] = DATA_W'(r);
        assign lane_c[g]   = c;
    end

    logic [DATA_W-1:0] sel_res;
    logic              sel_c;
    logic              nxt_n;
    logic              nxt_z;

    always_comb begin
        unique case (size)
            2'd0: begin
                sel_res = lane_res[0];
                sel_c   = lane_c[0];
            end
            2'd1: begin
                sel_res = lane_res[1];
                sel_c   = lane_c[1];
            end
            default: begin
                sel_res = lane_res[2];
                sel_c   = lane_c[2];
            end
        endcase
    end

    shrot_flags #(.DATA_W(DATA_W)) u_flags (
        .res  (sel_res),
        .size (size),
        .neg  (nxt_n),
        .zero (nxt_z)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sel_res;
                flag_n <= nxt_n;
                flag_z <= nxt_z;
                flag_v <= 1'b0;
                flag_c <= sel_c;
            end
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] operand,
    input logic              carry_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c
);
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'd0) |-> (result[DATA_W-1:DATA_W/4] == '0));

    a_r3_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 4'd0 && $past(size) == 2'd2)
        |-> (flag_c == $past(operand[DATA_W-1]) && result[0] == 1'b0));

    a_r9_invert_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 4'd8) |-> (flag_c == $past(carry_in)));

    a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flag_v);
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [1:0]  size;
    logic [31:0] operand;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .operand(operand), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd2: return "R3";
            4'd1:       return "R4";
            4'd3:       return "R5";
            4'd4:       return "R6";
            4'd5:       return "R7";
            4'd6, 4'd7: return "R8";
            4'd8:       return "R9";
            default:    return "R12";
        endcase
    endfunction

    // returns {valid, result[31:0], n, z, v, c}
    function automatic logic [36:0] model(input logic [3:0] o, input logic [1:0] s,
                                          input logic [31:0] x, input logic ci);
        int w;
        logic [31:0] mask, a, r;
        logic top, lsb, c;
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        a = x & mask;
        top = a[w-1];
        lsb = a[0];
        case (o)
            4'd0, 4'd2: begin r = (a << 1) & mask; c = top; end
            4'd1: begin r = a >> 1; c = lsb; end
            4'd3: begin r = (a >> 1) | (32'(top) << (w-1)); c = lsb; end
            4'd4: begin r = ((a << 1) & mask) | 32'(top); c = top; end
            4'd5: begin r = (a >> 1) | (32'(lsb) << (w-1)); c = lsb; end
            4'd6: begin r = ((a << 1) & mask) | 32'(ci); c = top; end
            4'd7: begin r = (a >> 1) | (32'(ci) << (w-1)); c = lsb; end
            4'd8: begin r = ~a & mask; c = ci; end
            default: begin r = a; c = ci; end
        endcase
        return {1'b1, r, r[w-1], (r == 32'd0), 1'b0, c};
    endfunction

    task automatic compare(input string tag, input logic [36:0] got, input logic [36:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [31:0] x,
                       input logic ci, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = s; operand = x; carry_in = ci;
        @(negedge clk);
        compare(tag, {out_valid, result, flag_n, flag_z, flag_v, flag_c}, model(o, s, x, ci));
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        rst_n = 1'b0; in_valid = 1'b0; op = 4'd0; size = 2'd0; operand = 32'd0; carry_in = 1'b0;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        compare("R1", {out_valid, result, flag_n, flag_z, flag_v, flag_c}, 37'd0);
        rst_n = 1'b1;

        // R2: garbage above the width is ignored, result zero above width
        run(4'd0, 2'd0, 32'hFFFF_FF81, 1'b0, "R2");
        run(4'd1, 2'd1, 32'hABCD_8001, 1'b1, "R2");
        run(4'd4, 2'd3, 32'h8000_0001, 1'b0, "R2");
        // R1: strobe falls one cycle after request ends
        @(negedge clk);
        compare("R1", {36'd0, out_valid}, 37'd0);
        // directed shift and rotate corners
        run(4'd2, 2'd2, 32'h8000_0000, 1'b0, "R3");
        run(4'd1, 2'd0, 8'h01,         1'b0, "R4");
        run(4'd3, 2'd0, 8'h81,         1'b0, "R5");
        run(4'd3, 2'd1, 16'h4000,      1'b1, "R5");
        run(4'd4, 2'd0, 8'h80,         1'b0, "R6");
        run(4'd5, 2'd1, 16'h0001,      1'b0, "R7");
        run(4'd6, 2'd0, 8'h00,         1'b1, "R8");
        run(4'd7, 2'd2, 32'h0000_0001, 1'b1, "R8");
        run(4'd8, 2'd0, 8'hFF,         1'b1, "R9");
        run(4'd8, 2'd1, 16'h0000,      1'b0, "R9");
        run(4'd0, 2'd1, 16'h8000,      1'b0, "R10");
        run(4'd5, 2'd0, 8'h01,         1'b0, "R10");
        run(4'd3, 2'd2, 32'hFFFF_FFFF, 1'b0, "R11");
        run(4'd11, 2'd1, 32'h1234_8765, 1'b1, "R12");
        run(4'd15, 2'd0, 32'h0000_0000, 1'b0, "R12");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            run(ro, 2'($urandom_range(0, 3)), $urandom, 1'($urandom_range(0, 1)), tag_of(ro));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule